// File: doc/BRIEF.md
# Multi-Channel Memory-Mapped Timer

This block is a bank of identical 32-bit timer channels. A simple word-addressed register bus reaches the whole bank. Each channel has four words:
- a control word that also carries status,
- a load word,
- a live counter word,
- a spare word.

Software picks the counting direction for each channel, arms the channel by writing its enable bit, and can ask for the channel to reload itself when it expires.

When a channel reaches its terminal value, it raises a sticky pending flag. The pending flags of all channels, each gated by that channel's interrupt-enable bit, are ORed onto a single interrupt line.

The counters advance on a tick-enable input, not on every clock. An external divider can therefore set the counting rate. Reads return data one cycle after the strobe, together with a valid pulse.

Top module: `tmr_bank`

## Requirements
- R1: Word address `a` selects channel `a>>2` and word `a[1:0]`: 0 = control, 1 = load, 2 = counter. Word 3, and any channel index at or above NUM_CH, reads as zero, and writes to them change no channel state.
- R2: A read strobe in one cycle produces `bus_rvalid` high in the next cycle, with `bus_rdata` holding the value the addressed word had when the strobe was sampled. `bus_rvalid` is low in every other cycle.
- R3: A control write with bit 7 (enable) set copies the load word into the counter and starts the channel. Control reads return the written bits, with bit 8 showing the pending flag.
- R4: With bit 1 = 1 (down), a running channel decrements by one per tick. The tick taken while the counter is zero is its expiry.
- R5: With bit 1 = 0 (up), a running channel increments by one per tick, starting from the load value. The tick taken while the counter is 0xFFFFFFFF is its expiry.
- R6: An expiry sets the channel's pending flag, which reads as control bit 8.
- R7: On expiry with bit 4 (auto-reload) set, the counter takes the load value and keeps running. With bit 4 clear, the counter holds and bit 7 clears.
- R8: While bit 7 is clear, ticks have no effect on the counter.
- R9: A control write with bit 8 set clears the pending flag. A control write with bit 8 clear leaves it unchanged. Bit 8 is never stored from a write. If a write and an expiry coincide, the write wins.
- R10: `irq` is high exactly when some channel has its pending flag and its bit 6 (interrupt enable) both set. It reflects a write or an expiry from the cycle after that edge onward.
- R11: Synchronous reset clears every control, load and counter word and every pending flag, and drives `irq` and `bus_rvalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable for all running channels |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Shared interrupt |

## Verification
Writes, ticks and expiries all take effect at the clock edge where they are sampled. A read strobed in the following cycle shows the new state, and its data and valid pulse arrive one edge after that strobe. The interrupt is a combination of registered flags, so it changes in the cycle right after the edge that set or cleared a flag or enable bit.

The bench drives every input on the falling edge and lets one rising edge pass. On the next falling edge it samples `bus_rvalid`, `bus_rdata` and `irq` against a model that has been stepped once. That places every comparison exactly one register stage after its stimulus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int WORD_W   = 32;
    localparam int BIT_DOWN = 1;
    localparam int BIT_AUTO = 4;
    localparam int BIT_IE   = 6;
    localparam int BIT_EN   = 7;
    localparam int BIT_PEND = 8;

    localparam logic [WORD_W-1:0] PEND_MASK = WORD_W'(1) << BIT_PEND;
    localparam logic [WORD_W-1:0] ALL_ONES  = '1;

    typedef enum logic [1:0] {
        W_CTRL  = 2'd0,
        W_LOAD  = 2'd1,
        W_COUNT = 2'd2,
        W_SPARE = 2'd3
    } word_e;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] load;
        logic [WORD_W-1:0] cnt;
        logic              pend;
    } chan_state_t;

    function automatic logic at_terminal(input logic down, input logic [WORD_W-1:0] cnt);
        return down ? (cnt == '0) : (cnt == ALL_ONES);
    endfunction

    function automatic logic [WORD_W-1:0] step_count(input logic down, input logic [WORD_W-1:0] cnt);
        return down ? (cnt - WORD_W'(1)) : (cnt + WORD_W'(1));
    endfunction

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 6,
    parameter int CH_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch,
    output word_e             word,
    output logic              hit
);
    localparam int IW = ADDR_W - 2;
    localparam logic [31:0] NUM_U = NUM_CH;

    logic [IW-1:0] idx;

    always_comb begin
        idx  = addr[ADDR_W-1:2];
        ch   = idx[CH_W-1:0];
        word = word_e'(addr[1:0]);
        hit  = ({{(32-IW){1'b0}}, idx} < NUM_U);
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_ctrl,
    input  logic              wr_load,
    input  logic [WORD_W-1:0] wdata,
    output chan_state_t       st_q
);
    logic running;
    logic down;
    logic term;

    always_comb begin
        running = st_q.ctrl[BIT_EN];
        down    = st_q.ctrl[BIT_DOWN];
        term    = at_terminal(down, st_q.cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (wr_ctrl) begin
                st_q.ctrl <= wdata & ~PEND_MASK;
                if (wdata[BIT_PEND]) begin
                    st_q.pend <= 1'b0;
                end
                if (wdata[BIT_EN]) begin
                    st_q.cnt <= st_q.load;
                end
            end else if (running && tick) begin
                if (term) begin
                    st_q.pend <= 1'b1;
                    if (st_q.ctrl[BIT_AUTO]) begin
                        st_q.cnt <= st_q.load;
                    end else begin
                        st_q.ctrl[BIT_EN] <= 1'b0;
                    end
                end else begin
                    st_q.cnt <= step_count(down, st_q.cnt);
                end
            end
            if (wr_load) begin
                st_q.load <= wdata;
            end
        end
    end
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic [NUM_CH-1:0][WORD_W-1:0] ctrl_v,
    input  logic [NUM_CH-1:0][WORD_W-1:0] load_v,
    input  logic [NUM_CH-1:0][WORD_W-1:0] cnt_v,
    input  logic [NUM_CH-1:0]             pend_v,
    input  logic [CH_W-1:0]               ch,
    input  word_e                         word,
    input  logic                          hit,
    output logic [WORD_W-1:0]             rd_word
);
    always_comb begin
        rd_word = '0;
        if (hit) begin
            unique case (word)
                W_CTRL:  rd_word = ctrl_v[ch] | (pend_v[ch] ? PEND_MASK : '0);
                W_LOAD:  rd_word = load_v[ch];
                W_COUNT: rd_word = cnt_v[ch];
                W_SPARE: rd_word = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              irq
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [CH_W-1:0] sel_ch;
    word_e           sel_word;
    logic            sel_hit;

    chan_state_t [NUM_CH-1:0]      st_v;
    logic [NUM_CH-1:0][WORD_W-1:0] ctrl_v;
    logic [NUM_CH-1:0][WORD_W-1:0] load_v;
    logic [NUM_CH-1:0][WORD_W-1:0] cnt_v;
    logic [NUM_CH-1:0]             pend_v;
    logic [NUM_CH-1:0]             ie_v;
    logic [NUM_CH-1:0]             wr_ctrl_v;
    logic [NUM_CH-1:0]             wr_load_v;
    logic [WORD_W-1:0]             rd_word;
    logic [WORD_W-1:0]             rdata_q;
    logic                          rvalid_q;

    tmr_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
        .addr (bus_addr),
        .ch   (sel_ch),
        .word (sel_word),
        .hit  (sel_hit)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel_me;
        assign sel_me       = bus_wr && sel_hit && (sel_ch == CH_W'(i));
        assign wr_ctrl_v[i] = sel_me && (sel_word == W_CTRL);
        assign wr_load_v[i] = sel_me && (sel_word == W_LOAD);

        tmr_channel u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .wr_ctrl (wr_ctrl_v[i]),
            .wr_load (wr_load_v[i]),
            .wdata   (bus_wdata),
            .st_q    (st_v[i])
        );

        assign ctrl_v[i] = st_v[i].ctrl;
        assign load_v[i] = st_v[i].load;
        assign cnt_v[i]  = st_v[i].cnt;
        assign pend_v[i] = st_v[i].pend;
        assign ie_v[i]   = st_v[i].ctrl[BIT_IE];
    end

    tmr_rd_mux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_mux (
        .ctrl_v  (ctrl_v),
        .load_v  (load_v),
        .cnt_v   (cnt_v),
        .pend_v  (pend_v),
        .ch      (sel_ch),
        .word    (sel_word),
        .hit     (sel_hit),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd) begin
                rdata_q <= rd_word;
            end
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign irq        = |(pend_v & ie_v);
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 6
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          tick,
    input logic                          bus_wr,
    input logic                          bus_rd,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [31:0]                   bus_wdata,
    input logic [31:0]                   bus_rdata,
    input logic                          bus_rvalid,
    input logic                          irq,
    input logic [NUM_CH-1:0][WORD_W-1:0] ctrl_v,
    input logic [NUM_CH-1:0][WORD_W-1:0] load_v,
    input logic [NUM_CH-1:0][WORD_W-1:0] cnt_v,
    input logic [NUM_CH-1:0]             pend_v,
    input logic [NUM_CH-1:0]             wr_ctrl_v
);
    AST_RVALID_LAT: assert property (@(posedge clk) disable iff (rst) bus_rd |=> bus_rvalid); // R2
    AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst) !bus_rd |=> !bus_rvalid); // R2
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_rd && bus_addr[1:0] == 2'd3) |=> (bus_rdata == '0)); // R1
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst) $rose(irq) |-> (((pend_v & ~$past(pend_v)) != '0) || $past(bus_wr))); // R10

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst) (wr_ctrl_v[i] && bus_wdata[BIT_PEND]) |=> !pend_v[i]); // R9
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!ctrl_v[i][BIT_EN] && !wr_ctrl_v[i]) |=> $stable(cnt_v[i])); // R8
        AST_PEND_ON_TICK: assert property (@(posedge clk) disable iff (rst) $rose(pend_v[i]) |-> $past(tick)); // R6
        AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst) ($rose(pend_v[i]) && !ctrl_v[i][BIT_AUTO]) |-> !ctrl_v[i][BIT_EN]); // R7
        AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (rst) ($rose(pend_v[i]) && ctrl_v[i][BIT_AUTO]) |-> (ctrl_v[i][BIT_EN] && cnt_v[i] == $past(load_v[i]))); // R7
    end
endmodule

bind tmr_bank tmr_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq        (irq),
    .ctrl_v     (ctrl_v),
    .load_v     (load_v),
    .cnt_v      (cnt_v),
    .pend_v     (pend_v),
    .wr_ctrl_v  (wr_ctrl_v)
);

// File: tb/sim_tmr_bank.sv
`timescale 1ns/1ps
module sim_tmr_bank;
    localparam int N  = 4;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_ctrl [N];
    logic [31:0] m_load [N];
    logic [31:0] m_cnt  [N];
    logic        m_pend [N];

    always #10 clk = ~clk;

    tmr_bank #(.NUM_CH(N), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq)
    );

    task automatic check_eq(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_ctrl[i] = '0; m_load[i] = '0; m_cnt[i] = '0; m_pend[i] = 1'b0;
        end
    endtask

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        int c = int'(a >> 2);
        if (c >= N) return '0;
        case (a[1:0])
            2'd0: return m_ctrl[c] | (m_pend[c] ? 32'h100 : 32'h0);
            2'd1: return m_load[c];
            2'd2: return m_cnt[c];
            default: return '0;
        endcase
    endfunction

    function automatic logic model_irq();
        logic r = 1'b0;
        for (int i = 0; i < N; i++) r |= m_pend[i] & m_ctrl[i][6];
        return r;
    endfunction

    task automatic model_step(input logic wr, input logic [AW-1:0] a, input logic [31:0] d, input logic tk);
        int c = int'(a >> 2);
        for (int i = 0; i < N; i++) begin
            logic [31:0] old_load = m_load[i];
            if (wr && c == i && a[1:0] == 2'd0) begin
                m_ctrl[i] = d & ~32'h100;
                if (d[8]) m_pend[i] = 1'b0;
                if (d[7]) m_cnt[i] = old_load;
            end else if (m_ctrl[i][7] && tk) begin
                if (m_ctrl[i][1] ? (m_cnt[i] == 32'h0) : (m_cnt[i] == 32'hFFFF_FFFF)) begin
                    m_pend[i] = 1'b1;
                    if (m_ctrl[i][4]) m_cnt[i] = old_load;
                    else m_ctrl[i][7] = 1'b0;
                end else begin
                    m_cnt[i] = m_ctrl[i][1] ? m_cnt[i] - 1 : m_cnt[i] + 1;
                end
            end
            if (wr && c == i && a[1:0] == 2'd1) m_load[i] = d;
        end
    endtask

    // one bus cycle: drive at falling edge, check at the next falling edge
    task automatic do_cycle(input logic wr, input logic rd, input logic [AW-1:0] a,
                            input logic [31:0] d, input logic tk, input string tag);
        logic [31:0] exp;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick = tk;
        exp = model_read(a);
        @(posedge clk);
        model_step(wr, a, d, tk);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; tick = 1'b0;
        check_eq({31'b0, bus_rvalid}, {31'b0, rd}, "R2 rvalid");
        if (rd) check_eq(bus_rdata, exp, tag);
        check_eq({31'b0, irq}, {31'b0, model_irq()}, "R10 irq");
    endtask

    task automatic read_expect(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        do_cycle(1'b0, 1'b1, a, 32'h0, 1'b0, tag);
        check_eq(bus_rdata, exp, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        do_cycle(1'b1, 1'b0, a, d, 1'b0, "R2 write");
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) do_cycle(1'b0, 1'b0, '0, '0, 1'b1, "tick");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        read_expect(6'd0, 32'h0, "R11 ctrl");
        read_expect(6'd1, 32'h0, "R11 load");
        read_expect(6'd2, 32'h0, "R11 count");
        check_eq({31'b0, irq}, 32'h0, "R11 irq");

        // down one-shot on channel 0
        wr(6'd1, 32'd3);
        wr(6'd0, 32'hC2);
        read_expect(6'd2, 32'd3, "R3 count loaded");
        read_expect(6'd0, 32'hC2, "R3 ctrl readback");
        ticks(3);
        read_expect(6'd2, 32'd0, "R4 down count");
        check_eq({31'b0, irq}, 32'h0, "R10 no irq before expiry");
        ticks(1);
        read_expect(6'd0, 32'h142, "R6 R7 pending and stopped");
        check_eq({31'b0, irq}, 32'h1, "R10 irq asserted");
        ticks(2);
        read_expect(6'd2, 32'd0, "R8 hold while disabled");

        // R9 pending clear semantics
        wr(6'd0, 32'h42);
        read_expect(6'd0, 32'h142, "R9 bit8 clear keeps pending");
        wr(6'd0, 32'h142);
        read_expect(6'd0, 32'h42, "R9 bit8 set clears pending");
        check_eq({31'b0, irq}, 32'h0, "R10 irq dropped");

        // up auto-reload on channel 1
        wr(6'd5, 32'hFFFF_FFFD);
        wr(6'd4, 32'h90);
        ticks(2);
        read_expect(6'd6, 32'hFFFF_FFFF, "R5 up count");
        ticks(1);
        read_expect(6'd6, 32'hFFFF_FFFD, "R7 auto reload");
        read_expect(6'd4, 32'h190, "R6 pending, still enabled");
        check_eq({31'b0, irq}, 32'h0, "R10 masked by bit6");

        // R1 unused word and out-of-range channel
        wr(6'd11, 32'hDEAD_BEEF);
        read_expect(6'd11, 32'h0, "R1 spare word");
        wr(6'd40, 32'h0000_00C2);
        read_expect(6'd40, 32'h0, "R1 out-of-range channel");
        read_expect(6'd8, 32'h0, "R1 channel 2 ctrl untouched");
        read_expect(6'd9, 32'h0, "R1 channel 2 load untouched");

        // R11 reset while running
        wr(6'd0, 32'hC2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        read_expect(6'd5, 32'h0, "R11 load cleared");
        read_expect(6'd4, 32'h0, "R11 ctrl cleared");
        check_eq({31'b0, irq}, 32'h0, "R11 irq low");

        // constrained random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic          w  = ($urandom % 4) == 0;
            logic          r  = ($urandom % 2) == 0;
            logic          tk = ($urandom % 2) == 0;
            logic [AW-1:0] a  = AW'($urandom % 20);
            logic [31:0]   d;
            if (a[1:0] == 2'd1)
                d = ($urandom % 2) ? 32'($urandom % 12) : (32'hFFFF_FFF4 | 32'($urandom % 12));
            else
                d = $urandom & 32'h0000_01D2;
            do_cycle(w, r, a, d, tk, "R1 R2 random read");
        end

        summary();
        $finish;
    end
endmodule